// File: doc/BRIEF.md
# Horizontal Sync Period Meter

This block times an asynchronous horizontal sync input in system clock cycles. The raw sync pin is brought into the clock domain and its rising edges are found. A free-running counter measures the spacing of consecutive rising edges. On each edge the count is moved into an 8-bit period register that the host can only read, and the counter starts again. At a 2 MHz clock each count stands for 0.5 µs, so the host can tell the line rate and the video mode from the register.

A sync stream that is too slow cannot be measured. If no edge arrives within 255 cycles, the counter stops at its ceiling and does not wrap. The horizontal-detect flag then drops. An edge that ends such an overlong interval leaves the period register as it was.

The vertical sync input is used only for its trailing (falling) edge. The first line period that spans that edge is not reliable. The block therefore tags the captured value with a status bit, which stays set for as long as that value is on display.

Top module: `hsync_period_meter`

## Requirements
- R1: During and right after synchronous reset, `period_q` reads 0x00 and both `hdet_q` and `first_after_vsync_q` read 0.
- R2: If the gap between consecutive rising edges of `hsync_in` is P cycles, with P from 4 to 255, then `period_q` reads P. The new value is visible after the third rising clock edge that follows the sampled rise of `hsync_in`.
- R3: If 256 or more cycles pass without a rising edge, `hdet_q` is cleared before the next edge is captured. The edge that ends such an interval leaves `period_q` unchanged and `hdet_q` at 0.
- R4: The cycle counter saturates at 255 and does not wrap. An interval of 300 cycles must not be reported as a short valid period such as 44.
- R5: Each capture of an in-range interval sets `hdet_q` to 1. This includes the first capture after an overflowed interval.
- R6: The first rising edge of `hsync_in` after reset only starts the measurement. It captures nothing: `period_q` stays 0x00 and `hdet_q` stays 0.
- R7: A falling edge on `vsync_in` marks the next in-range capture: `first_after_vsync_q` reads 1 while that value is held. The capture after that clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Raw horizontal sync pin, asynchronous |
| vsync_in | input | 1 | Raw vertical sync pin, asynchronous |
| period_q | output | 8 | Last valid horizontal period in clock cycles (read only) |
| hdet_q | output | 1 | Horizontal sync detected and in range |
| first_after_vsync_q | output | 1 | Held period is the first one after the vertical sync trailing edge |

## Verification
The bench sweeps every period from 4 to 255 cycles and checks each captured value against the spacing it drove. A counter that is off by one, or that starts from the wrong value, fails on every line of the sweep. At the overflow boundary, 255 cycles must capture and 256 must not. An interval of 300 cycles catches a counter that wraps, because such a counter would report 44 with detect set instead of clearing the flag. Separate checks cover the arm-only first edge and the exact capture after a vertical trailing edge at which the tag rises and falls. A design that captured on its first edge, or that tagged the wrong line, would show a wrong period or a wrong status bit at one of those checks.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    parameter int unsigned PERIOD_W = 8;

    typedef logic [PERIOD_W-1:0] period_t;

    localparam period_t PERIOD_MAX = '1;
    localparam period_t PERIOD_ONE = period_t'(1);

    // What a detected horizontal edge does to the capture stage
    typedef enum logic [1:0] {
        EV_NONE       = 2'd0,
        EV_ARM        = 2'd1,
        EV_VALID      = 2'd2,
        EV_OVERFLOWED = 2'd3
    } cap_ev_e;

    typedef struct packed {
        logic hdet;
        logic first;
    } meter_stat_t;

    function automatic period_t sat_inc(input period_t v);
        return (v == PERIOD_MAX) ? v : period_t'(v + 1'b1);
    endfunction

endpackage

// File: rtl/hpm_sync_edge.sv
module hpm_sync_edge #(
    parameter int unsigned STAGES  = 2,
    parameter bit          FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic pulse_o
);
    localparam int unsigned MSB = STAGES - 1;

    logic [MSB:0] chain;
    logic         last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[MSB-1:0], async_i};
            last  <= chain[MSB];
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse_o = last & ~chain[MSB];
        end else begin : g_rise
            assign pulse_o = ~last & chain[MSB];
        end
    endgenerate

    // R2: an edge of one polarity can never repeat in the next cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/hpm_period_counter.sv
module hpm_period_counter
    import hpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart_i,
    output period_t cnt_o,
    output logic    ovf_o,
    output logic    ovf_evt_o
);
    period_t cnt;
    logic    ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (restart_i) begin
            cnt <= PERIOD_ONE;
            ovf <= 1'b0;
        end else begin
            cnt <= sat_inc(cnt);
            if (cnt == PERIOD_MAX) begin
                ovf <= 1'b1;
            end
        end
    end

    assign ovf_evt_o = !restart_i && (cnt == PERIOD_MAX) && !ovf;
    assign cnt_o     = cnt;
    assign ovf_o     = ovf;

    // R4: the counter holds at its ceiling until the next edge
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == PERIOD_MAX && !restart_i) |=> (cnt == PERIOD_MAX));

    // R3: an overflow event leaves the sticky overflow state set
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_evt_o |=> ovf);

    // R2: a restart always begins a fresh interval at one
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt == PERIOD_ONE && !ovf));

endmodule

// File: rtl/hpm_capture.sv
module hpm_capture
    import hpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    edge_i,
    input  period_t cnt_i,
    input  logic    ovf_i,
    input  logic    ovf_evt_i,
    input  logic    vs_fall_i,
    output period_t period_o,
    output logic    hdet_o,
    output logic    first_o
);
    cap_ev_e     ev;
    logic        armed;
    logic        pending;
    period_t     period;
    meter_stat_t stat;

    always_comb begin
        if (!edge_i)     ev = EV_NONE;
        else if (!armed) ev = EV_ARM;
        else if (ovf_i)  ev = EV_OVERFLOWED;
        else             ev = EV_VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            pending <= 1'b0;
            period  <= '0;
            stat    <= '0;
        end else begin
            if (ev == EV_ARM) begin
                armed <= 1'b1;
            end
            if (ev == EV_VALID) begin
                period     <= cnt_i;
                stat.hdet  <= 1'b1;
                stat.first <= pending;
            end else if (ovf_evt_i) begin
                stat.hdet  <= 1'b0;
            end
            if (vs_fall_i) begin
                pending <= 1'b1;
            end else if (ev == EV_VALID || ev == EV_OVERFLOWED) begin
                pending <= 1'b0;
            end
        end
    end

    assign period_o = period;
    assign hdet_o   = stat.hdet;
    assign first_o  = stat.first;

    // R2/R5: an in-range capture loads the count and sets detect
    p_valid_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_VALID) |=> (period == $past(cnt_i) && stat.hdet));

    // R3: overflow drops detect in the following cycle
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_evt_i |=> !stat.hdet);

    // R4: an edge after an overflowed interval changes nothing
    p_overflowed_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_OVERFLOWED) |=> (!stat.hdet && $stable(period)));

    // R6: the arming edge captures nothing
    p_arm_only_r6: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_ARM) |=> (!stat.hdet && $stable(period)));

    // R7: the tag only changes on an in-range capture
    p_first_source_r7: assert property (@(posedge clk) disable iff (rst)
        (ev != EV_VALID) |=> $stable(stat.first));

endmodule

// File: rtl/hsync_period_meter.sv
module hsync_period_meter
    import hpm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_in,
    input  logic                vsync_in,
    output logic [PERIOD_W-1:0] period_q,
    output logic                hdet_q,
    output logic                first_after_vsync_q
);
    logic    hs_rise;
    logic    vs_fall;
    period_t cnt;
    logic    ovf;
    logic    ovf_evt;

    hpm_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_hs_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (hsync_in),
        .pulse_o (hs_rise)
    );

    hpm_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_vs_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (vsync_in),
        .pulse_o (vs_fall)
    );

    hpm_period_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .restart_i (hs_rise),
        .cnt_o     (cnt),
        .ovf_o     (ovf),
        .ovf_evt_o (ovf_evt)
    );

    hpm_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (hs_rise),
        .cnt_i     (cnt),
        .ovf_i     (ovf),
        .ovf_evt_i (ovf_evt),
        .vs_fall_i (vs_fall),
        .period_o  (period_q),
        .hdet_o    (hdet_q),
        .first_o   (first_after_vsync_q)
    );

    // R1: nothing is reported in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (period_q == '0 && !hdet_q && !first_after_vsync_q));

endmodule

// File: tb/hsync_period_meter_tb.sv
module hsync_period_meter_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_in;
    logic       vsync_in;
    logic [7:0] period_q;
    logic       hdet_q;
    logic       first_after_vsync_q;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    int exp_per;
    int exp_h;
    int exp_f;

    always #2 clk = ~clk;

    hsync_period_meter u_dut (
        .clk                 (clk),
        .rst                 (rst),
        .hsync_in            (hsync_in),
        .vsync_in            (vsync_in),
        .period_q            (period_q),
        .hdet_q              (hdet_q),
        .first_after_vsync_q (first_after_vsync_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Rising edge now, high for two cycles, next rise p cycles later.
    // After the third clock edge the capture of the previous gap is checked.
    task automatic gap(input int p, input string req, input bit chk_end, input int vs_at);
        hsync_in = 1'b1;
        for (int i = 1; i <= p; i++) begin
            @(negedge clk);
            if (i == 2) hsync_in = 1'b0;
            if (i == vs_at) vsync_in = 1'b0;
            if (i == 3) begin
                chk(req, "period", int'(period_q), exp_per);
                chk(req, "hdet", int'(hdet_q), exp_h);
                chk(req, "first", int'(first_after_vsync_q), exp_f);
            end
            if (chk_end && i == p) chk("R3", "hdet before edge", int'(hdet_q), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int prev;
        rst = 1'b1;
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "period in reset", int'(period_q), 0);
        chk("R1", "hdet in reset", int'(hdet_q), 0);
        chk("R1", "first in reset", int'(first_after_vsync_q), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "period after reset", int'(period_q), 0);

        // R6: first edge only arms
        exp_per = 0; exp_h = 0; exp_f = 0;
        gap(20, "R6", 1'b0, 0);
        prev = 20;

        // R2: every period from 4 to 255
        for (int p = 4; p <= 255; p++) begin
            exp_per = prev; exp_h = 1; exp_f = 0;
            gap(p, "R2", 1'b0, 0);
            prev = p;
        end

        // 255 captured, then a 300-cycle gap overflows (R3)
        exp_per = 255; exp_h = 1; exp_f = 0;
        gap(300, "R2", 1'b1, 0);
        // R4: no wrap into a short period
        exp_per = 255; exp_h = 0;
        gap(50, "R4", 1'b0, 0);
        // R5: detect returns on next in-range interval
        exp_per = 50; exp_h = 1;
        gap(256, "R5", 1'b0, 0);
        // R3: 256 is out of range
        exp_per = 50; exp_h = 0;
        gap(40, "R3", 1'b0, 0);
        exp_per = 40; exp_h = 1;
        gap(40, "R5", 1'b0, 0);

        // R7: vertical trailing edge tags the next capture only
        vsync_in = 1'b1;
        exp_per = 40; exp_h = 1; exp_f = 0;
        gap(60, "R7", 1'b0, 10);
        exp_per = 60; exp_f = 1;
        gap(70, "R7", 1'b0, 0);
        exp_per = 70; exp_f = 0;
        gap(80, "R7", 1'b0, 0);
        exp_per = 80; exp_f = 0;
        gap(30, "R7", 1'b0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule